// File: doc/BRIEF.md
# Multi-Mode Byte Multiplier

This unit multiplies two operand words (eight bits wide by default) for a small CPU datapath and returns a double-width product as a high half and a low half. A three-bit operation code picks how the operands are read: both unsigned, both two's complement, or first signed with second unsigned. A fractional flag, the top bit of the code, shifts the product left by one place. The fractional modes support fixed-point arithmetic in which each operand has one integer bit.

A one-cycle start strobe launches a multiply. The result, a one-cycle done pulse and the updated zero and carry flags appear a fixed two cycles later. The block reports which half of the result goes to which destination: the low half always goes on its own port, bound for the lower-numbered register of the pair. Register writeback and instruction decode belong to the host.

Top module: `mulx_unit`

## Requirements
- R1: Operation code 3'b000 multiplies both operands as unsigned numbers and returns the 2W-bit product.
- R2: Operation code 3'b001 multiplies both operands as two's complement numbers.
- R3: Operation code 3'b010 treats the first operand (opa) as two's complement and the second (opb) as unsigned.
- R4: When op[2] is 1 (codes 3'b100, 3'b101, 3'b110), the result is the product of the mode chosen by op[1:0], shifted left by one bit and truncated to 2W bits. Bit 0 of the result is 0.
- R5: The carry flag equals bit 2W-1 of the product before any fractional shift.
- R6: The zero flag is 1 exactly when the whole 2W-bit result, after any shift, is zero.
- R7: A start sampled high by an idle unit at a clock edge gives done high and a valid result, zero flag and carry flag after the second following edge. Done is high for exactly one cycle.
- R8: A start that is high during the busy cycle between acceptance and completion is ignored. A start that is high in the cycle in which done is high is accepted.
- R9: The result and both flags keep their values in every cycle that does not follow a busy cycle.
- R10: After reset, done, the result and both flags are all 0.
- R11: op[1:0] = 2'b11 behaves like unsigned-by-unsigned, so code 3'b011 acts as code 3'b000 and code 3'b111 acts as code 3'b100.
- R12: The signed fractional product of the most negative operand by itself wraps to 1 followed by 2W-1 zeros, with carry 0. For W=8, 0x80 times 0x80 gives 0x8000.
- R13: The low W bits of the result come out on res_lo, bound for the lower-numbered destination. The high W bits come out on res_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply |
| op | input | 3 | Operation code: bit 2 selects fractional, bits 1:0 select signedness |
| opa | input | OPW | First operand |
| opb | input | OPW | Second operand |
| res_hi | output | OPW | High half of the result |
| res_lo | output | OPW | Low half of the result, for the lower-numbered destination |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |

## Verification
The bench builds two copies of the unit. The first has OPW=4 and the shift-and-add product variant. Its small width lets the bench sweep every operand pair under all eight operation codes, so every sign, shift and flag combination is reached, the reserved codes included. The second has the default OPW=8 and the multiply-operator variant. It covers the byte-wide corner cases: the most-negative wrap in signed fractional mode, all-ones operands in each mode and zero products. It also covers the port each result half comes out on, a start issued during the busy cycle, and holding the result between completions.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

   typedef enum logic [1:0] {
      SG_UU  = 2'b00,
      SG_SS  = 2'b01,
      SG_SU  = 2'b10,
      SG_RSV = 2'b11
   } sign_sel_e;

   typedef struct packed {
      logic sgn_a;
      logic sgn_b;
      logic frac;
   } mode_t;

   function automatic mode_t decode_op(input logic [2:0] op);
      mode_t m;
      m.frac = op[2];
      unique case (sign_sel_e'(op[1:0]))
         SG_SS:   begin m.sgn_a = 1'b1; m.sgn_b = 1'b1; end
         SG_SU:   begin m.sgn_a = 1'b1; m.sgn_b = 1'b0; end
         default: begin m.sgn_a = 1'b0; m.sgn_b = 1'b0; end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/mulx_opnd_ext.sv
module mulx_opnd_ext #(
   parameter int W = 8
) (
   input  logic [W-1:0]    d,
   input  logic            sgn,
   output logic signed [W:0] ext
);
   if (W < 2) begin : g_bad_w
      $error("mulx_opnd_ext: W must be at least 2");
   end

   assign ext = {sgn & d[W-1], d};

endmodule

// File: rtl/mulx_prod_core.sv
module mulx_prod_core #(
   parameter int W        = 8,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  mulx_pkg::mode_t mode,
   output logic [2*W-1:0] res,
   output logic           carry,
   output logic           zero
);
   localparam int PW = 2*W + 2;
   localparam int RW = 2*W;

   logic signed [W:0]    a_s;
   logic signed [W:0]    b_s;
   logic signed [PW-1:0] full;
   logic [RW-1:0]        prod;

   mulx_opnd_ext #(.W(W)) u_ext_a (.d(a), .sgn(mode.sgn_a), .ext(a_s));
   mulx_opnd_ext #(.W(W)) u_ext_b (.d(b), .sgn(mode.sgn_b), .ext(b_s));

   if (SHIFT_ADD) begin : g_shift_add
      logic signed [PW-1:0] a_w;
      logic signed [PW-1:0] acc [0:W+1];
      assign a_w    = PW'(a_s);
      assign acc[0] = '0;
      for (genvar i = 0; i <= W; i++) begin : g_row
         if (i < W) begin : g_pos
            assign acc[i+1] = acc[i] + (b_s[i] ? (a_w <<< i) : '0);
         end else begin : g_neg
            assign acc[i+1] = acc[i] - (b_s[i] ? (a_w <<< i) : '0);
         end
      end
      assign full = acc[W+1];
   end else begin : g_operator
      assign full = a_s * b_s;
   end

   assign prod  = full[RW-1:0];
   assign carry = prod[RW-1];
   assign res   = mode.frac ? {prod[RW-2:0], 1'b0} : prod;
   assign zero  = ~|res;

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit #(
   parameter int OPW       = 8,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     op,
   input  logic [OPW-1:0] opa,
   input  logic [OPW-1:0] opb,
   output logic [OPW-1:0] res_hi,
   output logic [OPW-1:0] res_lo,
   output logic           done,
   output logic           zf,
   output logic           cf
);
   localparam int RW = 2*OPW;

   if (OPW < 2 || OPW > 16) begin : g_bad_opw
      $error("mulx_unit: OPW out of supported range 2..16");
   end

   logic            busy_q;
   logic [OPW-1:0]  a_q, b_q;
   logic [2:0]      op_q;
   logic [RW-1:0]   res_q;
   logic            zf_q, cf_q, done_q;
   logic            accept;
   mulx_pkg::mode_t mode_q;
   logic [RW-1:0]   core_res;
   logic            core_c, core_z;

   assign accept = start & ~busy_q;
   assign mode_q = mulx_pkg::decode_op(op_q);

   // stage one: capture operands
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         op_q   <= '0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            a_q  <= opa;
            b_q  <= opb;
            op_q <= op;
         end
      end
   end

   mulx_prod_core #(.W(OPW), .SHIFT_ADD(SHIFT_ADD)) u_core (
      .a(a_q), .b(b_q), .mode(mode_q),
      .res(core_res), .carry(core_c), .zero(core_z)
   );

   // stage two: register result and flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         zf_q   <= 1'b0;
         cf_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy_q;
         if (busy_q) begin
            res_q <= core_res;
            zf_q  <= core_z;
            cf_q  <= core_c;
         end
      end
   end

   assign res_lo = res_q[OPW-1:0];
   assign res_hi = res_q[RW-1:OPW];
   assign done   = done_q;
   assign zf     = zf_q;
   assign cf     = cf_q;

   // R7
   accept_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> busy_q);
   // R7
   busy_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> done_q);
   // R7
   done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(busy_q));
   // R8
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> $stable({res_q, zf_q, cf_q}));
   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (zf_q == (res_q == '0)));

endmodule

// File: tb/mulx_unit_bench.sv
module mulx_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       st4 = 0, st8 = 0;
   logic [2:0] op4 = 0, op8 = 0;
   logic [3:0] a4 = 0, b4 = 0, hi4, lo4;
   logic [7:0] a8 = 0, b8 = 0, hi8, lo8;
   logic       d4, z4, c4, d8, z8, c8;

   int checks = 0;
   int errs   = 0;

   mulx_unit #(.OPW(4), .SHIFT_ADD(1'b1)) u_mulx_unit4 (
      .clk(clk), .rst_n(rst_n), .start(st4), .op(op4), .opa(a4), .opb(b4),
      .res_hi(hi4), .res_lo(lo4), .done(d4), .zf(z4), .cf(c4));

   mulx_unit #(.OPW(8), .SHIFT_ADD(1'b0)) u_mulx_unit (
      .clk(clk), .rst_n(rst_n), .start(st8), .op(op8), .opa(a8), .opb(b8),
      .res_hi(hi8), .res_lo(lo8), .done(d8), .zf(z8), .cf(c8));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(input int op);
      case (op & 3)
         1: return (op & 4) ? "R4/R2" : "R2";
         2: return (op & 4) ? "R4/R3" : "R3";
         3: return "R11";
         default: return (op & 4) ? "R4/R1" : "R1";
      endcase
   endfunction

   task automatic model(input int w, input int op, input int a, input int b,
                        output longint res, output int c);
      longint av = a, bv = b, p, mask;
      bit sa, sb;
      mask = (longint'(1) << (2*w)) - 1;
      sa = ((op & 3) == 1) || ((op & 3) == 2);
      sb = ((op & 3) == 1);
      if (sa && a >= (1 << (w-1))) av = a - (1 << w);
      if (sb && b >= (1 << (w-1))) bv = b - (1 << w);
      p = (av * bv) & mask;
      c = int'((p >> (2*w-1)) & 1);
      res = (op & 4) ? ((p << 1) & mask) : p;
   endtask

   task automatic drive(input int w, input bit s, input int op, input int a, input int b);
      if (w == 4) begin st4 = s; op4 = 3'(op); a4 = 4'(a); b4 = 4'(b); end
      else        begin st8 = s; op8 = 3'(op); a8 = 8'(a); b8 = 8'(b); end
   endtask

   task automatic issue(input int w, input int op, input int a, input int b, input bit ign);
      longint er, act;
      int ec;
      drive(w, 1'b1, op, a, b);
      @(posedge clk); @(negedge clk);
      if (ign) drive(w, 1'b1, op ^ 1, a ^ 1, b ^ 3);
      else     drive(w, 1'b0, 0, 0, 0);
      @(posedge clk); @(negedge clk);
      drive(w, 1'b0, 0, 0, 0);
      model(w, op, a, b, er, ec);
      if (w == 4) begin
         act = longint'({hi4, lo4});
         chk(mode_tag(op), act, er);
         chk("R5 carry", longint'(c4), longint'(ec));
         chk("R6 zero", longint'(z4), longint'(er == 0));
         chk("R7 done", longint'(d4), 1);
      end else begin
         chk(mode_tag(op), longint'({hi8, lo8}), er);
         chk("R13 res_lo", longint'(lo8), er & 8'hFF);
         chk("R13 res_hi", longint'(hi8), (er >> 8) & 8'hFF);
         chk("R5 carry", longint'(c8), longint'(ec));
         chk("R6 zero", longint'(z8), longint'(er == 0));
         chk("R7 done", longint'(d8), 1);
      end
      if (ign) begin
         @(posedge clk); @(negedge clk);
         chk("R8 ignored start no done", longint'(d8), 0);
         chk("R9 result kept", longint'({hi8, lo8}), er);
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst_n = 1'b1;
            // R10
            chk("R10 done", longint'(d8), 0);
            chk("R10 result", longint'({hi8, lo8}), 0);
            chk("R10 flags", longint'({z8, c8}), 0);
            chk("R10 result w4", longint'({hi4, lo4, d4, z4, c4}), 0);
            for (int op = 0; op < 8; op++)
               for (int a = 0; a < 16; a++)
                  for (int b = 0; b < 16; b++)
                     issue(4, op, a, b, 1'b0);
            // R12 signed fractional wrap
            issue(8, 5, 8'h80, 8'h80, 1'b0);
            chk("R12 wrap", longint'({hi8, lo8}), 16'h8000);
            chk("R12 carry", longint'(c8), 0);
            for (int op = 0; op < 8; op++) begin
               issue(8, op, 8'hFF, 8'hFF, 1'b0);
               issue(8, op, 8'h80, 8'h7F, 1'b0);
               issue(8, op, 8'h00, 8'h5A, 1'b0);
               issue(8, op, 8'h3C, 8'hC3, 1'b0);
            end
            // R8 start during busy ignored
            issue(8, 1, 8'h12, 8'hF3, 1'b1);
            // R9 and R7 pulse: idle cycles keep the result
            issue(8, 0, 8'h0F, 8'h11, 1'b0);
            repeat (2) begin
               @(posedge clk); @(negedge clk);
               chk("R7 done pulse low", longint'(d8), 0);
               chk("R9 hold", longint'({hi8, lo8, z8, c8}), longint'({16'h00FF, 2'b00}));
            end
         end
         begin
            repeat (100000) @(posedge clk);
            checks++; errs++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule